// File: doc/BRIEF.md
# Interrupt Status and Masking Unit

This block gathers interrupt conditions for a DMA-driven controller that runs an embedded script engine. Conditions come from two groups: DMA-type events and bus-side events. Each event is a one-cycle pulse, and the block latches it into a status register. Software can read the status registers, and a read clears the bits it returned. Each source has an enable bit. An enabled condition that is latched counts as fatal. A fatal condition requests a halt from the script engine and drives the active-low interrupt pin.

The pin has a separate mask. While the mask is set, the pin stays high, but nothing pending is lost: clearing the mask brings the pin back at once. The DMA status register also carries a DMA-FIFO-empty flag. That flag is status only: it never interrupts and a read never clears it. Raising an interrupt does not touch either FIFO. Software empties them through a command register that produces one-cycle clear and flush pulses.

Host access uses a plain address / read / write / data register bus. `reg_rdata` is combinational in the cycle `reg_rd` is high, and the read-clear takes effect at the end of that cycle. No data stream passes through this block, so no valid/ready handshake exists and the register bus has no back-pressure. While `engine_running` is high, only the summary register can be accessed. Every other read returns zero, and every other write is dropped.

Top module: `irq_status_unit`

## Requirements
- R1: Reading the DMA status register (address 1) returns the latched DMA conditions in bits 6:0 and clears the bits it returned. Reading bus status register A (address 3, sources 7:0) or B (address 4, sources 15:8) does the same for its sources.
- R2: Bit 7 of the DMA status register reflects the `dma_fifo_empty` input. It never affects `irq_n` or `halt_req`, and a read does not clear it.
- R3: While the pin-mask bit (bit 1 of the control register, address 7) is set, `irq_n` stays high, and all latched status and pending state is kept.
- R4: If the pin mask is cleared while a condition is pending, `irq_n` is low in the cycle after the write.
- R5: A DMA condition that is latched and enabled in the DMA enable register (address 2, bits 6:0) is fatal. In the cycle after the event, `halt_req` is high and `irq_n` is low (unless masked).
- R6: A latched bus-side condition whose enable bit is set (address 5 for sources 7:0, address 6 for sources 15:8) is fatal and raises `halt_req` and the pin. With the enable bit clear, the condition is held in status only.
- R7: An event that arrives in the same cycle as a read-clear of its status register stays latched for the next read.
- R8: Writing the FIFO command register (address 8) with bit 2, bit 1 or bit 0 set gives a one-cycle pulse, in the next cycle, on `dma_fifo_clr`, `bus_fifo_clr` or `dma_fifo_flush` respectively. Interrupts never produce these pulses.
- R9: While `engine_running` is high, reads of any address except 0 return zero and do not clear, and writes to any such address are ignored.
- R10: The summary register (address 0) returns bit 0 = OR of enabled latched DMA conditions and bit 1 = OR of enabled latched bus conditions. Its other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_rd | input | 1 | Read strobe; a read-clear takes effect at the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle reg_rd is high |
| engine_running | input | 1 | Script engine is executing; locks out non-summary access |
| dma_evt | input | 7 | DMA-type event pulses |
| bus_evt | input | 16 | Bus-side event pulses |
| dma_fifo_empty | input | 1 | DMA FIFO empty flag |
| irq_n | output | 1 | Active-low interrupt pin |
| halt_req | output | 1 | Fatal-condition halt request to the script engine |
| dma_fifo_clr | output | 1 | One-cycle DMA FIFO clear pulse |
| bus_fifo_clr | output | 1 | One-cycle bus-side FIFO clear pulse |
| dma_fifo_flush | output | 1 | One-cycle DMA FIFO flush pulse |

## Verification
The bench targets an event landing in the same cycle as a read-clear of its status register. A design that clears before it sets would lose that event for good. It also reads the DMA status register twice with the FIFO-empty flag high, which catches a read-clear that wipes bit 7 or lets it drive the pin. It latches a bus condition while its enable is off and then turns the enable on: a design that samples enables only at event time would never halt. It masks and unmasks the pin with a condition pending, which exposes a mask that discards state. It also accesses registers while the engine runs, which exposes writes that leak through or reads that clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 4;
  localparam int DMA_SRC  = REG_W - 1;
  localparam int BUS_SRC  = 2 * REG_W;

  typedef enum logic [ADDR_W-1:0] {
    A_SUMMARY = 4'd0,
    A_DSTAT   = 4'd1,
    A_DEN     = 4'd2,
    A_BSTAT_A = 4'd3,
    A_BSTAT_B = 4'd4,
    A_BEN_A   = 4'd5,
    A_BEN_B   = 4'd6,
    A_CTRL    = 4'd7,
    A_FIFOCMD = 4'd8
  } reg_sel_e;

  localparam int CTRL_MASK_BIT  = 1;
  localparam int CMD_DCLR_BIT   = 2;
  localparam int CMD_BCLR_BIT   = 1;
  localparam int CMD_FLUSH_BIT  = 0;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] stat
);
  // Set wins over clear so an event coinciding with a read survives.
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat[i] <= 1'b0;
      else if (evt[i]) stat[i] <= 1'b1;
      else if (clr[i]) stat[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [REG_W-1:0]   wdata,
  input  logic               running,
  input  logic [DMA_SRC-1:0] dstat,
  input  logic [BUS_SRC-1:0] bstat,
  input  logic               fifo_empty,
  input  logic               dma_pend,
  input  logic               bus_pend,
  output logic [REG_W-1:0]   rdata,
  output logic [DMA_SRC-1:0] den,
  output logic [BUS_SRC-1:0] ben,
  output logic               pin_mask,
  output logic [DMA_SRC-1:0] dclr,
  output logic [BUS_SRC-1:0] bclr,
  output logic               p_dclr,
  output logic               p_bclr,
  output logic               p_flush
);
  logic access_ok, rd_ok, wr_ok;
  assign access_ok = !running || (addr == A_SUMMARY);
  assign rd_ok     = rd && access_ok;
  assign wr_ok     = wr && access_ok;

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      case (addr)
        A_SUMMARY: rdata = {{(REG_W-2){1'b0}}, bus_pend, dma_pend};
        A_DSTAT:   rdata = {fifo_empty, dstat};
        A_DEN:     rdata = {1'b0, den};
        A_BSTAT_A: rdata = bstat[REG_W-1:0];
        A_BSTAT_B: rdata = bstat[BUS_SRC-1:REG_W];
        A_BEN_A:   rdata = ben[REG_W-1:0];
        A_BEN_B:   rdata = ben[BUS_SRC-1:REG_W];
        A_CTRL:    rdata = {{(REG_W-2){1'b0}}, pin_mask, 1'b0};
        default:   rdata = '0;
      endcase
    end
  end

  // Read clears whatever was reported; bit 7 (fifo_empty) is not stored here.
  assign dclr = (rd_ok && addr == A_DSTAT) ? dstat : '0;
  assign bclr[REG_W-1:0]       = (rd_ok && addr == A_BSTAT_A) ? bstat[REG_W-1:0] : '0;
  assign bclr[BUS_SRC-1:REG_W] = (rd_ok && addr == A_BSTAT_B) ? bstat[BUS_SRC-1:REG_W] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den      <= '0;
      ben      <= '0;
      pin_mask <= 1'b0;
      p_dclr   <= 1'b0;
      p_bclr   <= 1'b0;
      p_flush  <= 1'b0;
    end else begin
      p_dclr  <= wr_ok && addr == A_FIFOCMD && wdata[CMD_DCLR_BIT];
      p_bclr  <= wr_ok && addr == A_FIFOCMD && wdata[CMD_BCLR_BIT];
      p_flush <= wr_ok && addr == A_FIFOCMD && wdata[CMD_FLUSH_BIT];
      if (wr_ok) begin
        case (addr)
          A_DEN:   den <= wdata[DMA_SRC-1:0];
          A_BEN_A: ben[REG_W-1:0] <= wdata;
          A_BEN_B: ben[BUS_SRC-1:REG_W] <= wdata;
          A_CTRL:  pin_mask <= wdata[CTRL_MASK_BIT];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pkg::*;
(
  input  logic [DMA_SRC-1:0] dstat,
  input  logic [DMA_SRC-1:0] den,
  input  logic [BUS_SRC-1:0] bstat,
  input  logic [BUS_SRC-1:0] ben,
  input  logic               pin_mask,
  output logic               dma_pend,
  output logic               bus_pend,
  output logic               halt_req,
  output logic               irq_n
);
  assign dma_pend = |(dstat & den);
  assign bus_pend = |(bstat & ben);
  // Every enabled condition is fatal; the mask affects only the pin.
  assign halt_req = dma_pend || bus_pend;
  assign irq_n    = !((dma_pend || bus_pend) && !pin_mask);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               engine_running,
  input  logic [DMA_SRC-1:0] dma_evt,
  input  logic [BUS_SRC-1:0] bus_evt,
  input  logic               dma_fifo_empty,
  output logic               irq_n,
  output logic               halt_req,
  output logic               dma_fifo_clr,
  output logic               bus_fifo_clr,
  output logic               dma_fifo_flush
);
  logic [DMA_SRC-1:0] dstat, den, dclr;
  logic [BUS_SRC-1:0] bstat, ben, bclr;
  logic pin_mask, dma_pend, bus_pend;

  irq_latch_bank #(.N(DMA_SRC)) u_dma_bank (
    .clk(clk), .rst_n(rst_n), .evt(dma_evt), .clr(dclr), .stat(dstat));

  irq_latch_bank #(.N(BUS_SRC)) u_bus_bank (
    .clk(clk), .rst_n(rst_n), .evt(bus_evt), .clr(bclr), .stat(bstat));

  irq_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .rd(reg_rd), .wr(reg_wr),
    .wdata(reg_wdata), .running(engine_running), .dstat(dstat), .bstat(bstat),
    .fifo_empty(dma_fifo_empty), .dma_pend(dma_pend), .bus_pend(bus_pend),
    .rdata(reg_rdata), .den(den), .ben(ben), .pin_mask(pin_mask),
    .dclr(dclr), .bclr(bclr), .p_dclr(dma_fifo_clr), .p_bclr(bus_fifo_clr),
    .p_flush(dma_fifo_flush));

  irq_pin_ctrl u_pin (
    .dstat(dstat), .den(den), .bstat(bstat), .ben(ben), .pin_mask(pin_mask),
    .dma_pend(dma_pend), .bus_pend(bus_pend), .halt_req(halt_req), .irq_n(irq_n));
endmodule

// File: rtl/irq_checker.sv
module irq_checker
  import irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_rd,
  input logic               reg_wr,
  input logic [REG_W-1:0]   reg_wdata,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               engine_running,
  input logic [DMA_SRC-1:0] dma_evt,
  input logic [DMA_SRC-1:0] dstat,
  input logic [DMA_SRC-1:0] den,
  input logic               pin_mask,
  input logic               dma_pend,
  input logic               bus_pend,
  input logic               irq_n,
  input logic               halt_req,
  input logic               dma_fifo_clr
);
  assert_mask_holds_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mask |-> irq_n);

  assert_unmask_asserts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pin_mask) && (dma_pend || bus_pend)) |-> !irq_n);

  assert_dma_fatal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_evt & den) != '0) |=> halt_req);

  assert_evt_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_evt != '0) |=> ((dstat & $past(dma_evt)) == $past(dma_evt)));

  assert_fifo_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_fifo_clr |-> $past(reg_wr && reg_addr == A_FIFOCMD && reg_wdata[CMD_DCLR_BIT]
                           && !engine_running));

  assert_locked_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && engine_running && reg_addr != A_SUMMARY) |-> reg_rdata == '0);
endmodule

bind irq_status_unit irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .engine_running(engine_running),
  .dma_evt(dma_evt), .dstat(dstat), .den(den), .pin_mask(pin_mask),
  .dma_pend(dma_pend), .bus_pend(bus_pend), .irq_n(irq_n), .halt_req(halt_req),
  .dma_fifo_clr(dma_fifo_clr));

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        engine_running = 1'b0;
  logic [6:0]  dma_evt = '0;
  logic [15:0] bus_evt = '0;
  logic        dma_fifo_empty = 1'b0;
  logic irq_n, halt_req, dma_fifo_clr, bus_fifo_clr, dma_fifo_flush;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit [6:0]  m_dst, m_den;
  bit [15:0] m_bst, m_ben;
  bit        m_mask, m_pd, m_pb, m_pf;

  always #10 clk = ~clk;

  irq_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .engine_running(engine_running),
    .dma_evt(dma_evt), .bus_evt(bus_evt), .dma_fifo_empty(dma_fifo_empty),
    .irq_n(irq_n), .halt_req(halt_req), .dma_fifo_clr(dma_fifo_clr),
    .bus_fifo_clr(bus_fifo_clr), .dma_fifo_flush(dma_fifo_flush));

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit any_pend();
    return ((m_dst & m_den) != 0) || ((m_bst & m_ben) != 0);
  endfunction

  // One clock: drive at negedge, compare, advance model at the edge.
  task automatic cyc(input string req, input int a, input bit rd, input bit wr,
                     input int wd, input int de, input int be);
    int  exp_rd;
    bit  ok;
    bit [6:0]  nd;
    bit [15:0] nb;
    reg_addr = a[3:0]; reg_rd = rd; reg_wr = wr; reg_wdata = wd[7:0];
    dma_evt = de[6:0]; bus_evt = be[15:0];
    #2;
    ok = !engine_running || a == 0;
    exp_rd = 0;
    if (rd && ok) begin
      if (a == 0)      exp_rd = {((m_bst & m_ben) != 0), ((m_dst & m_den) != 0)};
      else if (a == 1) exp_rd = {dma_fifo_empty, m_dst};
      else if (a == 2) exp_rd = m_den;
      else if (a == 3) exp_rd = m_bst[7:0];
      else if (a == 4) exp_rd = m_bst[15:8];
      else if (a == 5) exp_rd = m_ben[7:0];
      else if (a == 6) exp_rd = m_ben[15:8];
      else if (a == 7) exp_rd = m_mask ? 2 : 0;
    end
    if (rd) chk({req, " rdata"}, reg_rdata, exp_rd);
    chk({req, " halt_req"}, halt_req, any_pend());
    chk({req, " irq_n"}, irq_n, !(any_pend() && !m_mask));
    chk({req, " dma_fifo_clr"}, dma_fifo_clr, m_pd);
    chk({req, " bus_fifo_clr"}, bus_fifo_clr, m_pb);
    chk({req, " dma_fifo_flush"}, dma_fifo_flush, m_pf);
    nd = m_dst; nb = m_bst;
    if (rd && ok && a == 1) nd = 0;
    if (rd && ok && a == 3) nb[7:0] = 0;
    if (rd && ok && a == 4) nb[15:8] = 0;
    nd |= de[6:0]; nb |= be[15:0];
    m_pd = wr && ok && a == 8 && wd[2];
    m_pb = wr && ok && a == 8 && wd[1];
    m_pf = wr && ok && a == 8 && wd[0];
    if (wr && ok) begin
      if (a == 2) m_den = wd[6:0];
      if (a == 5) m_ben[7:0] = wd[7:0];
      if (a == 6) m_ben[15:8] = wd[7:0];
      if (a == 7) m_mask = wd[1];
    end
    @(posedge clk);
    m_dst = nd; m_bst = nb;
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; dma_evt = '0; bus_evt = '0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset irq_n", irq_n, 1);
    chk("reset halt_req", halt_req, 0);
    chk("reset pulses", {dma_fifo_clr, bus_fifo_clr, dma_fifo_flush}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R10 summary idle", 0, 1, 0, 0, 0, 0);
    cyc("R5 den", 2, 0, 1, 8'h7F, 0, 0);
    cyc("R6 ben A", 5, 0, 1, 8'h0F, 0, 0);
    // R5: DMA events fatal
    cyc("R5 dma evt", 0, 0, 0, 0, 7'h05, 0);
    cyc("R10 summary dma", 0, 1, 0, 0, 0, 0);
    dma_fifo_empty = 1'b1;
    cyc("R1 read dstat", 1, 1, 0, 0, 0, 0);
    cyc("R2 bit7 kept", 1, 1, 0, 0, 0, 0);
    cyc("R2 no irq", 0, 0, 0, 0, 0, 0);
    // R6: disabled bus source is status only, then enabling promotes it
    cyc("R6 disabled evt", 0, 0, 0, 0, 0, 16'h0210);
    cyc("R6 status only", 0, 1, 0, 0, 0, 0);
    cyc("R1 read bstat A", 3, 1, 0, 0, 0, 0);
    cyc("R6 enable B", 6, 0, 1, 8'h02, 0, 0);
    cyc("R6 fatal bus", 0, 1, 0, 0, 0, 0);
    // R3/R4 pin mask
    cyc("R3 mask on", 7, 0, 1, 8'h02, 0, 0);
    cyc("R3 masked", 7, 1, 0, 0, 7'h01, 0);
    cyc("R3 still pending", 0, 1, 0, 0, 0, 0);
    cyc("R4 unmask", 7, 0, 1, 8'h00, 0, 0);
    cyc("R4 pin low", 0, 0, 0, 0, 0, 0);
    // R7: event coinciding with read-clear
    cyc("R7 read+evt", 1, 1, 0, 0, 7'h01, 0);
    cyc("R7 kept", 1, 1, 0, 0, 0, 0);
    cyc("R7 bus read+evt", 4, 1, 0, 0, 0, 16'h0200);
    cyc("R7 bus kept", 4, 1, 0, 0, 0, 0);
    // R9: lockout while running
    cyc("R9 seed", 0, 0, 0, 0, 7'h02, 0);
    engine_running = 1'b1;
    cyc("R9 read blocked", 1, 1, 0, 0, 0, 0);
    cyc("R9 write blocked", 2, 0, 1, 8'h00, 0, 0);
    cyc("R9 cmd blocked", 8, 0, 1, 8'h07, 0, 0);
    cyc("R9 summary ok", 0, 1, 0, 0, 0, 0);
    engine_running = 1'b0;
    cyc("R9 den intact", 2, 1, 0, 0, 0, 0);
    cyc("R9 dstat intact", 1, 1, 0, 0, 0, 0);
    // R8: FIFO command pulses
    cyc("R8 all cmds", 8, 0, 1, 8'h07, 0, 0);
    cyc("R8 pulse", 0, 0, 0, 0, 0, 0);
    cyc("R8 self clear", 8, 0, 1, 8'h02, 0, 0);
    cyc("R8 bus only", 8, 0, 1, 8'h01, 0, 0);
    cyc("R8 flush only", 0, 0, 0, 0, 0, 0);
    cyc("R8 idle", 0, 0, 0, 0, 7'h7F, 0);
    cyc("R8 no pulse on irq", 0, 0, 0, 0, 0, 0);
    cyc("R1 final clear", 1, 1, 0, 0, 0, 0);
    cyc("R1 final clear B", 4, 1, 0, 0, 0, 0);
    cyc("R10 idle end", 0, 1, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule